// File: doc/BRIEF.md
# Aligned DMA Write Splitter with Status Ordering

This block sits between the producers of post-transaction memory writes in a USB host controller and the memory write port. Each request names a byte address (DWord aligned, 64 bits wide), a length in DWords and a kind: inbound payload or a descriptor status write-back. A request is cut into memory write commands that never cross a 16-DWord aligned boundary. The commands are issued in ascending address order, and each command carries a full set of byte enables.

A transaction is a series of payload requests, the final one flagged as last, plus one status write-back. The status write-back may arrive before, between or after the payload requests. It is parked in a one-entry slot. It is released only once every chunk of the last payload request has been accepted by the memory side. Payload for the next transaction is refused until that status write-back has been handed to the splitter. Both request and command sides use valid/ready handshakes.

Top module: `dma_wr_splitter`

## Requirements
- R1: After reset, `mem_valid` is 0 and `req_ready` is 1.
- R2: Every command has a length from 1 to 16 DWords and a DWord-aligned address (bits 1:0 zero), and the DWord index of its address modulo 16 plus its length never exceeds 16.
- R3: A request of L DWords at DWord offset o within its 16-DWord block produces a first command of min(L, 16 − o) DWords and then commands of min(remaining, 16) DWords. The commands have contiguous ascending addresses, and their lengths sum to L. This holds for L up to 257.
- R4: While `mem_valid` is 1 and `mem_ready` is 0, the command address, length and status tag stay unchanged and `mem_valid` stays 1.
- R5: While a payload request is being split, `req_ready` is 0 for a payload request (`req_kind` = 0).
- R6: A status write-back (`req_kind` = 1) is accepted into its slot whenever the slot is empty. Its commands appear only after every command of its transaction's payload requests, including the one flagged `req_last`. Commands of the next transaction's payload come only after it.
- R7: A zero-length payload request is accepted and produces no command. If it is flagged last, the held status write-back is released.
- R8: `mem_be` is 4'hF on every command. `mem_is_status` is 1 exactly for commands cut from a status write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_kind | input | 1 | 0 = inbound payload, 1 = status write-back |
| req_last | input | 1 | Payload request is the final one of its transaction |
| req_addr | input | 64 | Start byte address, DWord aligned |
| req_len | input | 9 | Length in DWords |
| mem_valid | output | 1 | Write command present |
| mem_ready | input | 1 | Write command taken when high with mem_valid |
| mem_addr | output | 64 | Command byte address |
| mem_len | output | 5 | Command length in DWords (1..16) |
| mem_be | output | 4 | Byte enables, all set |
| mem_is_status | output | 1 | Command belongs to a status write-back |

## Verification
A wrong remaining-length or chunk count shows at the command port within one handshake. It appears as a chunk that crosses a 16-DWord line, a short or extra command, or an address gap that breaks the running sum. A stale done flag or status slot shows as a status command that appears ahead of payload or never appears at all. The bench catches the first case as an order mismatch against its arithmetic list, and the second when the per-transaction drain wait expires. The sweep walks every start offset against lengths around one and two lines and the 257-DWord maximum, under a fixed stall pattern on `mem_ready`.

// File: rtl/dmawr_pkg.sv
`timescale 1ns/1ps
package dmawr_pkg;

    localparam int ADDR_W   = 64;
    localparam int LEN_W    = 9;
    localparam int CHUNK_DW = 16;
    localparam int BE_W     = 4;
    localparam int OFF_W    = $clog2(CHUNK_DW);
    localparam int CL_W     = OFF_W + 1;
    localparam int SPAN_W   = LEN_W + 1;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [LEN_W-1:0]  len_t;
    typedef logic [CL_W-1:0]   clen_t;

    typedef enum logic {
        WK_DATA   = 1'b0,
        WK_STATUS = 1'b1
    } wr_kind_e;

    typedef struct packed {
        addr_t    addr;
        len_t     remain;
        len_t     cnt;
        wr_kind_e kind;
        logic     last;
    } chunk_state_t;

    // DWord index of an address inside its aligned line
    function automatic logic [OFF_W-1:0] line_off(input addr_t a);
        return a[2 +: OFF_W];
    endfunction

    // Length of the next chunk starting at a with r DWords left
    function automatic clen_t next_len(input addr_t a, input len_t r);
        clen_t room;
        room = CL_W'(CHUNK_DW) - CL_W'(line_off(a));
        if (r < LEN_W'(room))
            return CL_W'(r);
        return room;
    endfunction

    // Number of chunks needed to cover r DWords starting at a
    function automatic len_t chunk_count(input addr_t a, input len_t r);
        logic [SPAN_W-1:0] span;
        if (r == '0)
            return '0;
        span = SPAN_W'(line_off(a)) + SPAN_W'(r) + SPAN_W'(CHUNK_DW - 1);
        return LEN_W'(span >> OFF_W);
    endfunction

endpackage

// File: rtl/wr_chunker.sv
`timescale 1ns/1ps
module wr_chunker
    import dmawr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  addr_t    ld_addr,
    input  len_t     ld_len,
    input  wr_kind_e ld_kind,
    input  logic     ld_last,
    input  logic     take,
    output logic     busy,
    output addr_t    ch_addr,
    output clen_t    ch_len,
    output wr_kind_e ch_kind,
    output logic     last_data_done
);

    chunk_state_t st;
    logic         fire;

    assign busy    = (st.cnt != '0);
    assign fire    = busy && take;
    assign ch_addr = st.addr;
    assign ch_len  = next_len(st.addr, st.remain);
    assign ch_kind = st.kind;
    assign last_data_done = fire && (st.cnt == LEN_W'(1))
                            && (st.kind == WK_DATA) && st.last;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (load) begin
            st.addr   <= {ld_addr[ADDR_W-1:2], 2'b00};
            st.remain <= ld_len;
            st.cnt    <= chunk_count(ld_addr, ld_len);
            st.kind   <= ld_kind;
            st.last   <= ld_last;
        end else if (fire) begin
            st.addr   <= st.addr + (ADDR_W'(ch_len) << 2);
            st.remain <= st.remain - LEN_W'(ch_len);
            st.cnt    <= st.cnt - LEN_W'(1);
        end
    end

    // R2: chunk stays inside one aligned line and is non-empty
    a_r2_no_cross: assert property (@(posedge clk) disable iff (rst)
        busy |-> (ch_len != '0) &&
                 ((CL_W+1)'(line_off(st.addr)) + (CL_W+1)'(ch_len) <= (CL_W+1)'(CHUNK_DW)));

    // R3: chunk counter and remaining length run out together
    a_r3_count_match: assert property (@(posedge clk) disable iff (rst)
        (st.cnt == '0) == (st.remain == '0));

    // R4: a stalled command holds
    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        busy && !take |=> busy && $stable(st.addr) && $stable(st.remain) && $stable(st.kind));

    // R5: never reloaded while splitting
    a_r5_no_reload: assert property (@(posedge clk) disable iff (rst)
        load |-> !busy);

endmodule

// File: rtl/wr_status_slot.sv
`timescale 1ns/1ps
module wr_status_slot
    import dmawr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  push,
    input  addr_t push_addr,
    input  len_t  push_len,
    input  logic  pop,
    output logic  full,
    output addr_t hold_addr,
    output len_t  hold_len
);

    always_ff @(posedge clk) begin
        if (rst) begin
            full      <= 1'b0;
            hold_addr <= '0;
            hold_len  <= '0;
        end else if (push) begin
            full      <= 1'b1;
            hold_addr <= push_addr;
            hold_len  <= push_len;
        end else if (pop) begin
            full      <= 1'b0;
        end
    end

    // R6: the single slot is never overwritten or drained while empty
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);
    a_r6_no_underflow: assert property (@(posedge clk) disable iff (rst)
        pop |-> full);

endmodule

// File: rtl/wr_txn_tracker.sv
`timescale 1ns/1ps
module wr_txn_tracker (
    input  logic clk,
    input  logic rst,
    input  logic data_done,
    input  logic status_go,
    output logic done
);

    always_ff @(posedge clk) begin
        if (rst)
            done <= 1'b0;
        else if (data_done)
            done <= 1'b1;
        else if (status_go)
            done <= 1'b0;
    end

    // R6: a transaction completes only once before its status leaves
    a_r6_single_done: assert property (@(posedge clk) disable iff (rst)
        data_done |-> !done);
    a_r6_release_after_done: assert property (@(posedge clk) disable iff (rst)
        status_go |-> done);

endmodule

// File: rtl/dma_wr_splitter.sv
`timescale 1ns/1ps
module dma_wr_splitter
    import dmawr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_kind,
    input  logic              req_last,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [CL_W-1:0]   mem_len,
    output logic [BE_W-1:0]   mem_be,
    output logic              mem_is_status
);

    logic     is_status;
    logic     chk_busy;
    logic     slot_full;
    logic     done;
    logic     data_ok;
    logic     data_acc;
    logic     st_push;
    logic     st_release;
    logic     load;
    logic     chunk_done;
    logic     txn_done;
    addr_t    slot_addr;
    len_t     slot_len;
    addr_t    ld_addr;
    len_t     ld_len;
    wr_kind_e ld_kind;
    logic     ld_last;
    wr_kind_e ch_kind;

    assign is_status  = (wr_kind_e'(req_kind) == WK_STATUS);
    assign data_ok    = !chk_busy && !done;
    assign req_ready  = is_status ? !slot_full : data_ok;
    assign data_acc   = req_valid && !is_status && data_ok;
    assign st_push    = req_valid && is_status && !slot_full;
    assign st_release = slot_full && done && !chk_busy;
    assign load       = data_acc || st_release;

    assign ld_addr = st_release ? slot_addr : req_addr;
    assign ld_len  = st_release ? slot_len  : req_len;
    assign ld_kind = st_release ? WK_STATUS : WK_DATA;
    assign ld_last = st_release ? 1'b1      : req_last;

    assign txn_done = chunk_done || (data_acc && req_last && (req_len == '0));

    wr_chunker u_chunker (
        .clk            (clk),
        .rst            (rst),
        .load           (load),
        .ld_addr        (ld_addr),
        .ld_len         (ld_len),
        .ld_kind        (ld_kind),
        .ld_last        (ld_last),
        .take           (mem_ready),
        .busy           (chk_busy),
        .ch_addr        (mem_addr),
        .ch_len         (mem_len),
        .ch_kind        (ch_kind),
        .last_data_done (chunk_done)
    );

    wr_status_slot u_slot (
        .clk       (clk),
        .rst       (rst),
        .push      (st_push),
        .push_addr (req_addr),
        .push_len  (req_len),
        .pop       (st_release),
        .full      (slot_full),
        .hold_addr (slot_addr),
        .hold_len  (slot_len)
    );

    wr_txn_tracker u_track (
        .clk       (clk),
        .rst       (rst),
        .data_done (txn_done),
        .status_go (st_release),
        .done      (done)
    );

    assign mem_valid     = chk_busy;
    assign mem_be        = '1;
    assign mem_is_status = (ch_kind == WK_STATUS);

    // R7: a zero-length payload request leaves the command port idle
    a_r7_zero_no_cmd: assert property (@(posedge clk) disable iff (rst)
        data_acc && (req_len == '0) |=> !mem_valid);

    // R4: a stalled command stays valid with the same address
    a_r4_port_hold: assert property (@(posedge clk) disable iff (rst)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_is_status));

    // R2: command address is DWord aligned
    a_r2_aligned: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> (mem_addr[1:0] == 2'b00));

endmodule

// File: tb/sim_dma_wr_splitter.sv
`timescale 1ns/1ps
module sim_dma_wr_splitter;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_kind = 1'b0;
    logic        req_last = 1'b0;
    logic [63:0] req_addr = '0;
    logic [8:0]  req_len = '0;
    logic        mem_valid;
    logic        mem_ready = 1'b1;
    logic [63:0] mem_addr;
    logic [4:0]  mem_len;
    logic [3:0]  mem_be;
    logic        mem_is_status;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    bit busy_send = 1'b0;

    logic [63:0] exp_addr [64];
    int          exp_len  [64];
    bit          exp_st   [64];
    int          exp_n = 0;
    int          got_n = 0;

    bit          prev_stall = 1'b0;
    logic [63:0] prev_addr = '0;
    logic [4:0]  prev_len = '0;

    always #10 clk = ~clk;

    dma_wr_splitter u0 (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_last(req_last), .req_addr(req_addr), .req_len(req_len),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
        .mem_len(mem_len), .mem_be(mem_be), .mem_is_status(mem_is_status)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic add_exp(input logic [63:0] a, input int len, input bit st);
        logic [63:0] cur;
        int rem;
        int off;
        int c;
        cur = a;
        rem = len;
        while (rem > 0) begin
            off = int'(cur[5:2]);
            c = (rem < 16 - off) ? rem : 16 - off;
            exp_addr[exp_n] = cur;
            exp_len[exp_n]  = c;
            exp_st[exp_n]   = st;
            exp_n++;
            cur = cur + 64'(c * 4);
            rem = rem - c;
        end
    endtask

    task automatic send(input bit kind, input bit last, input logic [63:0] a, input int len);
        @(negedge clk);
        busy_send = 1'b1;
        req_valid = 1'b1;
        req_kind  = kind;
        req_last  = last;
        req_addr  = a;
        req_len   = 9'(len);
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        req_kind  = 1'b0;
        req_last  = 1'b0;
        busy_send = 1'b0;
    endtask

    // Stall pattern on the command side
    initial begin
        forever begin
            @(posedge clk);
            #2;
            cyc++;
            mem_ready = ((cyc % 7) != 3) && ((cyc % 5) != 1);
        end
    end

    // Command monitor, sampled mid-cycle
    always @(negedge clk) begin
        if (!rst) begin
            if (prev_stall) begin
                check(mem_valid && mem_addr == prev_addr && mem_len == prev_len,
                      "R4", "stalled command changed", longint'(mem_addr), longint'(prev_addr));
            end
            prev_stall = mem_valid && !mem_ready;
            prev_addr  = mem_addr;
            prev_len   = mem_len;
            if (mem_valid && !mem_is_status && !busy_send) begin
                check(req_ready == 1'b0, "R5", "payload ready during split",
                      longint'(req_ready), 0);
            end
            if (mem_valid && mem_ready) begin
                check(mem_be == 4'hF, "R8", "byte enables", longint'(mem_be), 64'hF);
                check(int'(mem_addr[5:2]) + int'(mem_len) <= 16 && mem_len != 0,
                      "R2", "line crossing", longint'(mem_len), 16);
                if (got_n >= exp_n) begin
                    check(1'b0, "R3", "extra command", longint'(mem_addr), 0);
                end else begin
                    check(mem_addr == exp_addr[got_n], "R3", "chunk address",
                          longint'(mem_addr), longint'(exp_addr[got_n]));
                    check(int'(mem_len) == exp_len[got_n], "R3", "chunk length",
                          longint'(mem_len), longint'(exp_len[got_n]));
                    check(mem_is_status == exp_st[got_n], "R6", "status order",
                          longint'(mem_is_status), longint'(exp_st[got_n]));
                end
                got_n++;
            end
        end
    end

    task automatic drain(input string req);
        int waited;
        waited = 0;
        while (got_n < exp_n && waited < 3000) begin
            @(negedge clk);
            waited++;
        end
        repeat (4) @(negedge clk);
        check(got_n == exp_n, req, "command count", longint'(got_n), longint'(exp_n));
        check(mem_valid == 1'b0, req, "port idle after drain", longint'(mem_valid), 0);
        got_n = 0;
        exp_n = 0;
    endtask

    task automatic run_txn(input int t, input int off, input int len);
        logic [63:0] dbase;
        logic [63:0] sbase;
        int slen;
        int l1;
        dbase = (64'(t) << 36) + 64'h0000_0000_0040_0000 + 64'(off * 4);
        sbase = 64'h8000_0000_0000_1000 + 64'(t * 68);
        slen  = 1 + (t % 17);
        exp_n = 0;
        got_n = 0;
        if (len > 2 && (len % 3) == 0) begin
            // R6: status parked between two payload parts
            l1 = len / 3;
            add_exp(dbase, l1, 1'b0);
            add_exp(dbase + 64'(l1 * 4), len - l1, 1'b0);
            add_exp(sbase, slen, 1'b1);
            send(1'b0, 1'b0, dbase, l1);
            send(1'b1, 1'b0, sbase, slen);
            send(1'b0, 1'b1, dbase + 64'(l1 * 4), len - l1);
        end else if (((off + len) % 2) == 0) begin
            // R6: status arrives first and is held
            add_exp(dbase, len, 1'b0);
            add_exp(sbase, slen, 1'b1);
            send(1'b1, 1'b0, sbase, slen);
            send(1'b0, 1'b1, dbase, len);
        end else begin
            add_exp(dbase, len, 1'b0);
            add_exp(sbase, slen, 1'b1);
            send(1'b0, 1'b1, dbase, len);
            send(1'b1, 1'b0, sbase, slen);
        end
        drain(len == 0 ? "R7" : "R3");
    endtask

    initial begin
        int lens [25];
        int t;
        for (int i = 0; i < 21; i++) lens[i] = i;
        lens[21] = 31;
        lens[22] = 32;
        lens[23] = 33;
        lens[24] = 257;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(mem_valid == 1'b0, "R1", "mem_valid after reset", longint'(mem_valid), 0);
        check(req_ready == 1'b1, "R1", "req_ready after reset", longint'(req_ready), 1);
        t = 0;
        for (int off = 0; off < 16; off++) begin
            for (int k = 0; k < 25; k++) begin
                run_txn(t, off, lens[k]);
                t++;
            end
        end
        // R9-style maximum length is covered by lens[24]; R8 checked per command
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(20 * 190000);
        fails++;
        tests++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule